// File: doc/BRIEF.md
# Stepwise Left Rotator

This block keeps a 4-bit word in a register and turns it to the left by a requested number of places. A load strobe writes a new word. A start strobe captures a 2-bit amount and begins a rotation. The rotation moves the word one place per clock, so a request for three places takes three clock cycles. During each step the top bit wraps around into bit 0. While this runs, `busy` is high. `done` marks the final cycle of the rotation, which lets a caller issue the next command without polling.

The controller has three named states. ST_IDLE waits for a command. ST_SPIN performs one single-place turn per cycle and counts down the remaining places. ST_NULL is a one-cycle acknowledge that is used when the requested amount is zero. The transitions are:
- ST_IDLE or ST_NULL → ST_SPIN on a start with a non-zero amount.
- ST_IDLE or ST_NULL → ST_NULL on a start with a zero amount.
- ST_IDLE or ST_NULL → ST_IDLE on a load or when no command is given.
- ST_SPIN → ST_SPIN while more than one place remains.
- ST_SPIN → ST_IDLE on the final step.

The reset is synchronous and active high.

Top module: `bitrot_unit`

## Requirements
- R1: A clock edge with `rst` high clears `reg_q` to 0 and leaves `busy` and `done` low in the following cycle.
- R2: When the block is not busy and `load_en` is 1, `reg_q` equals `load_val` after the next clock edge.
- R3: A start with `amount` = k, where k is an unsigned binary value from 1 to 3, raises `busy` for exactly k cycles. In the i-th busy cycle (i counted from 1), `reg_q` shows the start word rotated left by i-1 places, with bit 3 wrapping into bit 0. After the last busy cycle, `reg_q` holds the start word rotated left by k places.
- R4: `done` is 1 in the last busy cycle of a rotation and is 0 in every other busy cycle.
- R5: A start with `amount` = 0 gives exactly one cycle with `done` = 1 and `busy` = 0, and `reg_q` does not change.
- R6: While `busy` is 1, `load_en` and `start_en` have no effect: the rotation finishes with its original amount and final value, and no new rotation follows it.
- R7: When `load_en` and `start_en` are both 1 in the same idle cycle, the load takes effect and no rotation starts, so `busy` and `done` stay 0.
- R8: After a rotation ends, `busy` and `done` are 0 and `reg_q` keeps the rotated value.
- R9: While the block is idle and neither strobe is given, `reg_q` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | Write `load_val` into the register |
| load_val | input | 4 | Word to be written |
| start_en | input | 1 | Capture `amount` and begin rotating |
| amount | input | 2 | Number of places to rotate left |
| reg_q | output | 4 | Current register contents |
| busy | output | 1 | High while a rotation is in progress |
| done | output | 1 | High in the final cycle of a rotation |

## Verification
Two pairs of events can fall in the same cycle. First, the final turning step coincides with the `done` pulse, so both `busy` and `done` are high together. The bench checks that cycle for the partly turned word and then expects both flags to be low on the next cycle. Second, a load and a start can be presented on the same idle edge. The bench drives both strobes at once and checks that the new word appears while `busy` and `done` stay low for two cycles. It also holds both strobes high across an entire rotation and checks that the turned values are not disturbed.

// File: rtl/bitrot_pkg.sv
package bitrot_pkg;

    // Controller states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // waiting for a command
        ST_SPIN = 2'd1,   // turning one place per cycle
        ST_NULL = 2'd2    // one-cycle acknowledge for a zero amount
    } rot_state_e;

endpackage

// File: rtl/bitrot_ctrl.sv
module bitrot_ctrl
    import bitrot_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load_en,
    input  logic start_en,
    input  logic amount_zero,
    input  logic last_step,
    output logic do_load,
    output logic do_start,
    output logic do_step,
    output logic busy,
    output logic done
);

    rot_state_e state_q, state_d;
    logic       accepting;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_NULL: begin
                if (do_start) begin
                    state_d = amount_zero ? ST_NULL : ST_SPIN;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_SPIN: begin
                state_d = last_step ? ST_IDLE : ST_SPIN;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs and datapath strobes
    always_comb begin
        accepting = 1'b0;
        busy      = 1'b0;
        done      = 1'b0;
        do_step   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                accepting = 1'b1;
            end
            ST_NULL: begin
                accepting = 1'b1;
                done      = 1'b1;
            end
            ST_SPIN: begin
                busy    = 1'b1;
                do_step = 1'b1;
                done    = last_step;
            end
            default: begin
                accepting = 1'b0;
            end
        endcase
        // the load strobe wins over the start strobe
        do_load  = accepting && load_en;
        do_start = accepting && !load_en && start_en;
    end

endmodule

// File: rtl/bitrot_count.sv
module bitrot_count #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cap,
    input  logic [CW-1:0] cap_val,
    input  logic          dec,
    output logic          last_step
);

    logic [CW-1:0] left_q;

    // Remaining-places counter
    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (cap) begin
            left_q <= cap_val;
        end else if (dec && left_q != '0) begin
            left_q <= left_q - CW'(1);
        end
    end

    assign last_step = (left_q == CW'(1));

endmodule

// File: rtl/bitrot_path.sv
module bitrot_path #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wr_val,
    input  logic         turn,
    output logic [W-1:0] word
);

    logic [W-1:0] word_q;
    logic [W-1:0] turned;

    // Single-place left turn: the top bit re-enters at bit 0
    generate
        if (W > 1) begin : g_wide
            assign turned = {word_q[W-2:0], word_q[W-1]};
        end else begin : g_narrow
            assign turned = word_q;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (wr) begin
            word_q <= wr_val;
        end else if (turn) begin
            word_q <= turned;
        end
    end

    assign word = word_q;

endmodule

// File: rtl/bitrot_unit.sv
module bitrot_unit #(
    parameter int WIDTH = 4,
    localparam int AMT_W = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_en,
    input  logic [WIDTH-1:0] load_val,
    input  logic             start_en,
    input  logic [AMT_W-1:0] amount,
    output logic [WIDTH-1:0] reg_q,
    output logic             busy,
    output logic             done
);

    logic do_load;
    logic do_start;
    logic do_step;
    logic last_step;
    logic amount_zero;

    assign amount_zero = (amount == '0);

    bitrot_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .load_en     (load_en),
        .start_en    (start_en),
        .amount_zero (amount_zero),
        .last_step   (last_step),
        .do_load     (do_load),
        .do_start    (do_start),
        .do_step     (do_step),
        .busy        (busy),
        .done        (done)
    );

    bitrot_count #(.CW(AMT_W)) u_count (
        .clk       (clk),
        .rst       (rst),
        .cap       (do_start),
        .cap_val   (amount),
        .dec       (do_step),
        .last_step (last_step)
    );

    bitrot_path #(.W(WIDTH)) u_path (
        .clk    (clk),
        .rst    (rst),
        .wr     (do_load),
        .wr_val (load_val),
        .turn   (do_step),
        .word   (reg_q)
    );

endmodule

// File: rtl/bitrot_unit_chk.sv
module bitrot_unit_chk #(
    parameter int WIDTH = 4,
    localparam int AMT_W = $clog2(WIDTH)
) (
    input logic             clk,
    input logic             rst,
    input logic             load_en,
    input logic [WIDTH-1:0] load_val,
    input logic             start_en,
    input logic [AMT_W-1:0] amount,
    input logic [WIDTH-1:0] reg_q,
    input logic             busy,
    input logic             done
);

    logic rst_seen;
    always_ff @(posedge clk) rst_seen <= rst;

    a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
        rst_seen |-> (reg_q == '0 && !busy && !done));

    a_r2_load_writes: assert property (@(posedge clk) disable iff (rst)
        (!busy && load_en) |=> (reg_q == $past(load_val)));

    a_r3_turn_per_cycle: assert property (@(posedge clk) disable iff (rst)
        busy |=> (reg_q == {$past(reg_q[WIDTH-2:0]), $past(reg_q[WIDTH-1])}));

    a_r4_done_closes_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && done) |=> !busy);

    a_r4_busy_continues: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

    a_r5_zero_ack: assert property (@(posedge clk) disable iff (rst)
        (!busy && start_en && !load_en && amount == '0)
            |=> (done && !busy && reg_q == $past(reg_q)));

    a_r7_load_wins: assert property (@(posedge clk) disable iff (rst)
        (!busy && load_en && start_en) |=> (!busy && !done));

endmodule

bind bitrot_unit bitrot_unit_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .load_en  (load_en),
    .load_val (load_val),
    .start_en (start_en),
    .amount   (amount),
    .reg_q    (reg_q),
    .busy     (busy),
    .done     (done)
);

// File: tb/bitrot_unit_test.sv
module bitrot_unit_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       load_en;
    logic [3:0] load_val;
    logic       start_en;
    logic [1:0] amount;
    logic [3:0] reg_q;
    logic       busy;
    logic       done;

    int n_checks = 0;
    int n_fails  = 0;

    always #10ns clk = ~clk;

    bitrot_unit uut (
        .clk      (clk),
        .rst      (rst),
        .load_en  (load_en),
        .load_val (load_val),
        .start_en (start_en),
        .amount   (amount),
        .reg_q    (reg_q),
        .busy     (busy),
        .done     (done)
    );

    function automatic logic [3:0] rotl(input logic [3:0] v, input int n);
        logic [3:0] r = v;
        for (int i = 0; i < n; i++) r = {r[2:0], r[3]};
        return r;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic quiet();
        load_en  = 1'b0;
        start_en = 1'b0;
        load_val = 4'h0;
        amount   = 2'd0;
    endtask

    // R1
    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        quiet();
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reg_q", 8'(reg_q), 8'h0);
        check("R1 busy", 8'(busy), 8'h0);
        check("R1 done", 8'(done), 8'h0);
    endtask

    // R2
    task automatic t_load(input logic [3:0] v);
        load_en  = 1'b1;
        load_val = v;
        @(negedge clk);
        quiet();
        check("R2 load value", 8'(reg_q), 8'(v));
    endtask

    // R3, R4, R8
    task automatic t_rotate(input logic [3:0] s, input logic [1:0] k);
        t_load(s);
        start_en = 1'b1;
        amount   = k;
        @(negedge clk);
        quiet();
        for (int i = 1; i <= int'(k); i++) begin
            check("R3 busy in run", 8'(busy), 8'h1);
            check("R3 partial word", 8'(reg_q), 8'(rotl(s, i - 1)));
            check("R4 done timing", 8'(done), 8'(i == int'(k)));
            @(negedge clk);
        end
        check("R8 busy after run", 8'(busy), 8'h0);
        check("R8 done after run", 8'(done), 8'h0);
        check("R3 final word", 8'(reg_q), 8'(rotl(s, int'(k))));
        @(negedge clk);
        check("R8 word holds", 8'(reg_q), 8'(rotl(s, int'(k))));
    endtask

    // R5
    task automatic t_zero(input logic [3:0] s);
        t_load(s);
        start_en = 1'b1;
        amount   = 2'd0;
        @(negedge clk);
        quiet();
        check("R5 done pulse", 8'(done), 8'h1);
        check("R5 no busy", 8'(busy), 8'h0);
        check("R5 word kept", 8'(reg_q), 8'(s));
        @(negedge clk);
        check("R5 done single", 8'(done), 8'h0);
        check("R5 still idle", 8'(busy), 8'h0);
        check("R5 word kept later", 8'(reg_q), 8'(s));
    endtask

    // R6
    task automatic t_busy_ignore();
        t_load(4'h1);
        start_en = 1'b1;
        amount   = 2'd2;
        @(negedge clk);
        load_en  = 1'b1;
        load_val = 4'hF;
        start_en = 1'b1;
        amount   = 2'd3;
        check("R6 busy 1", 8'(busy), 8'h1);
        check("R6 word 1", 8'(reg_q), 8'h1);
        @(negedge clk);
        check("R6 busy 2", 8'(busy), 8'h1);
        check("R6 done 2", 8'(done), 8'h1);
        check("R6 word 2", 8'(reg_q), 8'h2);
        @(negedge clk);
        quiet();
        check("R6 ends", 8'(busy), 8'h0);
        check("R6 final word", 8'(reg_q), 8'h4);
        @(negedge clk);
        check("R6 no restart", 8'(busy), 8'h0);
        check("R6 word stays", 8'(reg_q), 8'h4);
    endtask

    // R7
    task automatic t_conflict();
        t_load(4'h9);
        load_en  = 1'b1;
        load_val = 4'h6;
        start_en = 1'b1;
        amount   = 2'd2;
        @(negedge clk);
        quiet();
        check("R7 load applied", 8'(reg_q), 8'h6);
        check("R7 no busy", 8'(busy), 8'h0);
        check("R7 no done", 8'(done), 8'h0);
        @(negedge clk);
        check("R7 still idle", 8'(busy), 8'h0);
        check("R7 word stays", 8'(reg_q), 8'h6);
    endtask

    // R9
    task automatic t_hold();
        t_load(4'hA);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R9 idle hold", 8'(reg_q), 8'hA);
            check("R9 idle flags", 8'({busy, done}), 8'h0);
        end
    endtask

    initial begin
        rst = 1'b1;
        quiet();
        t_reset();
        t_hold();
        t_rotate(4'h9, 2'd3);
        t_rotate(4'h1, 2'd1);
        t_rotate(4'h8, 2'd2);
        t_rotate(4'h5, 2'd3);
        t_zero(4'hB);
        t_busy_ignore();
        t_conflict();
        t_reset();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule